// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block sits on the host side of a serial flash link and runs a complete erase on its own. A client hands over one request with a two-bit size selector and a 24-bit byte address. The sequencer then opens a write-enable transaction on the SPI pins. It follows this with the sized erase command and three address bytes, and releases chip select so the flash starts its self-timed erase. It then reads the status register again and again until the busy bit drops.

The client sees a valid/ready handshake and a single-cycle completion pulse. An error flag comes with that pulse if the flash stays busy for more status reads than a configured limit allows. The link runs in SPI mode 0. The serial clock is derived from the system clock by a parameter, and the chip-select idle gap between transactions is set by a second parameter.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sck` is 0, `req_ready` is 1, and `op_done` and `op_err` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the cycle in which `op_done` is 1, and it is 1 in that cycle.
- R3: The first transaction of every erase is exactly 8 bits carrying 0x06, framed by its own low period of `spi_cs_n`.
- R4: The second transaction is exactly 32 bits: an opcode followed by the address. The opcode is 0x20 for `req_size`=0 (4 KB), 0x52 for `req_size`=1 (32 KB), and 0xD8 for `req_size`=2 or 3 (64 KB).
- R5: The 24-bit address is sent most significant bit first, with the offset inside the erase unit forced to zero: bits 11..0 for 4 KB, bits 14..0 for 32 KB, and bits 15..0 for 64 KB.
- R6: Each following transaction is 16 bits: 0x05, then eight bits during which MOSI is 0 and MISO is captured on the rising edges of SCK. Bit 0 of the captured byte is the busy flag, and the other status bits have no effect. These transactions repeat while the busy flag reads 1.
- R7: The first status read with busy equal to 0 ends the erase with `op_done` high for exactly one cycle and `op_err` low.
- R8: If `POLL_LIMIT` status reads in a row all show busy, the erase ends after the last of them with `op_done` and `op_err` both high for one cycle. No further transaction follows.
- R9: SPI mode 0: `spi_sck` is 0 whenever `spi_cs_n` is 1, and `spi_mosi` changes only while `spi_sck` is 0.
- R10: Between two transactions `spi_cs_n` stays high for at least `2*SCK_HALF*CS_GAP_SCK` clock cycles.
- R11: A `req_valid` presented while `req_ready` is 0 is ignored. The erase in progress sends the same transactions it would send without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_size | input | 2 | Erase unit: 0 = 4 KB, 1 = 32 KB, 2/3 = 64 KB |
| req_addr | input | 24 | Byte address inside the unit to erase |
| op_done | output | 1 | One-cycle completion pulse |
| op_err | output | 1 | Poll limit exceeded; valid with op_done |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Most wrong internal states show up on the SPI pins well before any completion pulse. A bad opcode selection or address mask changes the 32-bit erase frame as soon as chip select rises at its end. A bit counter that is off by one gives a frame of the wrong length on the very first write-enable transaction. A fault in the status capture or the poll counter only becomes visible at the end of the run. It then appears as the wrong number of 16-bit status frames, or as an error flag that does not match the busy pattern the flash model returned. A lost handshake state shows as `req_ready` being high one cycle after acceptance.

// File: rtl/ferase_pkg.sv
package ferase_pkg;

    localparam logic [7:0] OPC_WR_ENABLE = 8'h06;
    localparam logic [7:0] OPC_RD_STATUS = 8'h05;
    localparam logic [7:0] OPC_ERASE_4K  = 8'h20;
    localparam logic [7:0] OPC_ERASE_32K = 8'h52;
    localparam logic [7:0] OPC_ERASE_64K = 8'hD8;

    localparam int FRAME_W = 32;
    localparam int NBITS_W = 6;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WREN,
        SEQ_ERASE,
        SEQ_POLL
    } seq_state_e;

    typedef enum logic [2:0] {
        LNK_IDLE,
        LNK_LOW,
        LNK_HIGH,
        LNK_TAIL,
        LNK_GAP
    } lnk_state_e;

endpackage

// File: rtl/erase_cmd_fmt.sv
module erase_cmd_fmt
    import ferase_pkg::*;
(
    input  logic [1:0]         unit_sel,
    input  logic [23:0]        byte_addr,
    output logic [FRAME_W-1:0] frame_word
);

    logic [7:0]  opcode;
    logic [23:0] keep_mask;

    always_comb begin
        unique case (unit_sel)
            2'd0: begin
                opcode    = OPC_ERASE_4K;
                keep_mask = 24'hFFF000;
            end
            2'd1: begin
                opcode    = OPC_ERASE_32K;
                keep_mask = 24'hFF8000;
            end
            default: begin
                opcode    = OPC_ERASE_64K;
                keep_mask = 24'hFF0000;
            end
        endcase
        frame_word = {opcode, byte_addr & keep_mask};
    end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import ferase_pkg::*;
#(
    parameter int SCK_HALF   = 2,
    parameter int CS_GAP_SCK = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic [NBITS_W-1:0] tx_bits,
    output logic               fin,
    output logic [7:0]         rx_byte,
    output logic               spi_sck,
    output logic               spi_cs_n,
    output logic               spi_mosi,
    input  logic               spi_miso
);

    localparam int GAP_CYC   = 2 * SCK_HALF * CS_GAP_SCK;
    localparam int CNT_MAX   = (GAP_CYC > SCK_HALF) ? GAP_CYC : SCK_HALF;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(SCK_HALF - 1);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);

    typedef struct packed {
        lnk_state_e         state;
        logic [CNT_W-1:0]   cnt;
        logic [NBITS_W-1:0] left;
        logic [FRAME_W-1:0] shreg;
        logic [7:0]         rx;
        logic               sck;
        logic               cs_n;
        logic               fin;
    } lnk_t;

    lnk_t lnk_d, lnk_q;

    always_comb begin
        lnk_d     = lnk_q;
        lnk_d.fin = 1'b0;
        unique case (lnk_q.state)
            LNK_IDLE: begin
                lnk_d.sck  = 1'b0;
                lnk_d.cs_n = 1'b1;
                if (start) begin
                    lnk_d.state = LNK_LOW;
                    lnk_d.cs_n  = 1'b0;
                    lnk_d.shreg = tx_word;
                    lnk_d.left  = tx_bits;
                    lnk_d.cnt   = '0;
                end
            end
            LNK_LOW: begin
                if (lnk_q.cnt == HALF_LAST) begin
                    lnk_d.state = LNK_HIGH;
                    lnk_d.sck   = 1'b1;
                    lnk_d.rx    = {lnk_q.rx[6:0], spi_miso};
                    lnk_d.cnt   = '0;
                end else begin
                    lnk_d.cnt = lnk_q.cnt + CNT_W'(1);
                end
            end
            LNK_HIGH: begin
                if (lnk_q.cnt == HALF_LAST) begin
                    lnk_d.sck   = 1'b0;
                    lnk_d.cnt   = '0;
                    lnk_d.left  = lnk_q.left - NBITS_W'(1);
                    lnk_d.shreg = {lnk_q.shreg[FRAME_W-2:0], 1'b0};
                    lnk_d.state = (lnk_q.left == NBITS_W'(1)) ? LNK_TAIL : LNK_LOW;
                end else begin
                    lnk_d.cnt = lnk_q.cnt + CNT_W'(1);
                end
            end
            LNK_TAIL: begin
                if (lnk_q.cnt == HALF_LAST) begin
                    lnk_d.cs_n  = 1'b1;
                    lnk_d.state = LNK_GAP;
                    lnk_d.cnt   = '0;
                end else begin
                    lnk_d.cnt = lnk_q.cnt + CNT_W'(1);
                end
            end
            LNK_GAP: begin
                if (lnk_q.cnt == GAP_LAST) begin
                    lnk_d.state = LNK_IDLE;
                    lnk_d.fin   = 1'b1;
                    lnk_d.cnt   = '0;
                end else begin
                    lnk_d.cnt = lnk_q.cnt + CNT_W'(1);
                end
            end
            default: lnk_d.state = LNK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lnk_q       <= '0;
            lnk_q.state <= LNK_IDLE;
            lnk_q.cs_n  <= 1'b1;
        end else begin
            lnk_q <= lnk_d;
        end
    end

    assign fin      = lnk_q.fin;
    assign rx_byte  = lnk_q.rx;
    assign spi_sck  = lnk_q.sck;
    assign spi_cs_n = lnk_q.cs_n;
    assign spi_mosi = lnk_q.shreg[FRAME_W-1];

    // Checker state: cycles spent deselected, saturating at the gap length
    localparam int HI_W = $clog2(GAP_CYC + 1);
    logic [HI_W-1:0] hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= HI_W'(GAP_CYC);
        end else if (!spi_cs_n) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q != HI_W'(GAP_CYC)) begin
            hi_cnt_q <= hi_cnt_q + HI_W'(1);
        end
    end

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck) else $error("sck high while deselected"); // R9

    AST_MOSI_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_mosi) |-> !spi_sck) else $error("mosi moved with sck high"); // R9

    AST_CS_GAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_cnt_q == HI_W'(GAP_CYC))) else $error("cs gap too short"); // R10

    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> spi_cs_n) else $error("start while selected"); // R3

endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
    import ferase_pkg::*;
#(
    parameter int POLL_LIMIT = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_size,
    input  logic [23:0]        req_addr,
    output logic               req_ready,
    output logic               op_done,
    output logic               op_err,
    output logic [1:0]         held_size,
    output logic [23:0]        held_addr,
    input  logic [FRAME_W-1:0] erase_word,
    output logic               xfer_start,
    output logic [FRAME_W-1:0] xfer_word,
    output logic [NBITS_W-1:0] xfer_bits,
    input  logic               xfer_fin,
    input  logic [7:0]         xfer_rx
);

    localparam int POLL_W = $clog2(POLL_LIMIT + 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);

    typedef struct packed {
        seq_state_e        state;
        logic              launched;
        logic [POLL_W-1:0] polls;
        logic [1:0]        size;
        logic [23:0]       addr;
        logic              done;
        logic              err;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        xfer_start = 1'b0;
        xfer_word  = '0;
        xfer_bits  = '0;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (req_valid) begin
                    seq_d.state    = SEQ_WREN;
                    seq_d.size     = req_size;
                    seq_d.addr     = req_addr;
                    seq_d.launched = 1'b0;
                    seq_d.polls    = '0;
                end
            end
            SEQ_WREN: begin
                xfer_word = {OPC_WR_ENABLE, 24'h0};
                xfer_bits = NBITS_W'(8);
                if (!seq_q.launched) begin
                    xfer_start     = 1'b1;
                    seq_d.launched = 1'b1;
                end else if (xfer_fin) begin
                    seq_d.launched = 1'b0;
                    seq_d.state    = SEQ_ERASE;
                end
            end
            SEQ_ERASE: begin
                xfer_word = erase_word;
                xfer_bits = NBITS_W'(32);
                if (!seq_q.launched) begin
                    xfer_start     = 1'b1;
                    seq_d.launched = 1'b1;
                end else if (xfer_fin) begin
                    seq_d.launched = 1'b0;
                    seq_d.state    = SEQ_POLL;
                end
            end
            SEQ_POLL: begin
                xfer_word = {OPC_RD_STATUS, 24'h0};
                xfer_bits = NBITS_W'(16);
                if (!seq_q.launched) begin
                    xfer_start     = 1'b1;
                    seq_d.launched = 1'b1;
                end else if (xfer_fin) begin
                    seq_d.launched = 1'b0;
                    if (!xfer_rx[0]) begin
                        seq_d.state = SEQ_IDLE;
                        seq_d.done  = 1'b1;
                    end else if (seq_q.polls == POLL_LAST) begin
                        seq_d.state = SEQ_IDLE;
                        seq_d.done  = 1'b1;
                        seq_d.err   = 1'b1;
                    end else begin
                        seq_d.polls = seq_q.polls + POLL_W'(1);
                    end
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= SEQ_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.state == SEQ_IDLE);
    assign op_done   = seq_q.done;
    assign op_err    = seq_q.err;
    assign held_size = seq_q.size;
    assign held_addr = seq_q.addr;

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready) else $error("ready stayed high"); // R2

    AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> req_ready) else $error("done without ready"); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done) else $error("done longer than a cycle"); // R7

    AST_ERR_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> op_done) else $error("error outside done"); // R8

    AST_NO_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !xfer_start) else $error("transaction while idle"); // R11

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import ferase_pkg::*;
#(
    parameter int SCK_HALF   = 2,
    parameter int CS_GAP_SCK = 2,
    parameter int POLL_LIMIT = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_size,
    input  logic [23:0] req_addr,
    output logic        op_done,
    output logic        op_err,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);

    logic [1:0]         held_size;
    logic [23:0]        held_addr;
    logic [FRAME_W-1:0] erase_word;
    logic               xfer_start;
    logic [FRAME_W-1:0] xfer_word;
    logic [NBITS_W-1:0] xfer_bits;
    logic               xfer_fin;
    logic [7:0]         xfer_rx;

    erase_cmd_fmt u_fmt (
        .unit_sel   (held_size),
        .byte_addr  (held_addr),
        .frame_word (erase_word)
    );

    erase_seq_ctrl #(
        .POLL_LIMIT (POLL_LIMIT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .op_done    (op_done),
        .op_err     (op_err),
        .held_size  (held_size),
        .held_addr  (held_addr),
        .erase_word (erase_word),
        .xfer_start (xfer_start),
        .xfer_word  (xfer_word),
        .xfer_bits  (xfer_bits),
        .xfer_fin   (xfer_fin),
        .xfer_rx    (xfer_rx)
    );

    spi_xfer_engine #(
        .SCK_HALF   (SCK_HALF),
        .CS_GAP_SCK (CS_GAP_SCK)
    ) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (xfer_start),
        .tx_word  (xfer_word),
        .tx_bits  (xfer_bits),
        .fin      (xfer_fin),
        .rx_byte  (xfer_rx),
        .spi_sck  (spi_sck),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso)
    );

endmodule

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;

    localparam int SCK_HALF   = 2;
    localparam int CS_GAP_SCK = 2;
    localparam int POLL_LIMIT = 6;
    localparam int MIN_GAP    = 2 * SCK_HALF * CS_GAP_SCK;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_size = 2'd0;
    logic [23:0] req_addr = 24'h0;
    logic        op_done;
    logic        op_err;
    logic        spi_sck;
    logic        spi_cs_n;
    logic        spi_mosi;
    logic        spi_miso;

    always #4 clk = ~clk;

    flash_erase_seq #(
        .SCK_HALF   (SCK_HALF),
        .CS_GAP_SCK (CS_GAP_SCK),
        .POLL_LIMIT (POLL_LIMIT)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .op_done   (op_done),
        .op_err    (op_err),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Flash-side monitor and status responder
    int          ntx = 0;
    int          tx_len  [0:63];
    logic [31:0] tx_data [0:63];
    int          poll_total = 0;
    int          poll_base  = 0;
    int          busy_cfg   = 0;
    int          bitcnt = 0;
    logic [31:0] shcap = '0;
    int          hi_run = 0;
    int          min_gap = 1000000;
    int          mode_viol = 0;
    logic        sck_prev = 1'b0;
    logic        cs_prev  = 1'b1;
    logic [7:0]  status_byte;

    assign status_byte = {6'b0, 1'b1, ((poll_total - poll_base) < busy_cfg)};
    assign spi_miso = (bitcnt >= 8 && bitcnt < 16) ? status_byte[15 - bitcnt] : 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n && spi_sck) mode_viol <= mode_viol + 1;
            if (cs_prev && !spi_cs_n) begin
                if (ntx > 0 && hi_run < min_gap) min_gap <= hi_run;
                bitcnt <= 0;
                shcap  <= '0;
            end
            if (!cs_prev && spi_cs_n) begin
                tx_len[ntx % 64]  <= bitcnt;
                tx_data[ntx % 64] <= shcap;
                ntx <= ntx + 1;
                if (bitcnt == 16 && shcap[15:8] == 8'h05) poll_total <= poll_total + 1;
            end
            if (!spi_cs_n && !sck_prev && spi_sck) begin
                shcap  <= {shcap[30:0], spi_mosi};
                bitcnt <= bitcnt + 1;
            end
            hi_run <= spi_cs_n ? hi_run + 1 : 0;
            sck_prev <= spi_sck;
            cs_prev  <= spi_cs_n;
        end
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic t_reset();
        check(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R1", "sck after reset", spi_sck, 0);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(op_done == 1'b0 && op_err == 1'b0, "R1", "done/err after reset",
              {op_done, op_err}, 0);
    endtask

    task automatic t_erase(input logic [1:0] sz, input logic [23:0] a, input int busy,
                           input logic [7:0] eop, input logic [23:0] eaddr,
                           input bit exp_err, input int exp_polls, input bit poke);
        int  base;
        bit  seen;
        int  ready_bad;
        base      = ntx;
        poll_base = poll_total;
        busy_cfg  = busy;
        seen      = 1'b0;
        ready_bad = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_size  = sz;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R2", "ready after accept", req_ready, 0);
        if (poke) begin
            req_valid = 1'b1;
            req_size  = 2'd1;
            req_addr  = 24'hABCDEF;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (req_ready) ready_bad++;
            end
            req_valid = 1'b0;
            check(ready_bad == 0, "R11", "ready during busy poke", ready_bad, 0);
        end
        for (int i = 0; i < 20000; i++) begin
            if (op_done) begin
                seen = 1'b1;
                break;
            end
            if (req_ready) ready_bad++;
            @(negedge clk);
        end
        check(seen, "R7", "done seen", seen, 1);
        check(ready_bad == 0, "R2", "ready low while running", ready_bad, 0);
        check(req_ready == 1'b1, "R2", "ready with done", req_ready, 1);
        if (exp_err)
            check(op_err == 1'b1, "R8", "err at timeout", op_err, 1);
        else
            check(op_err == 1'b0, "R7", "err on normal finish", op_err, 0);
        @(negedge clk);
        check(op_done == 1'b0, "R7", "done width", op_done, 0);
        repeat (30) @(negedge clk);
        check(ntx - base == 2 + exp_polls, "R8", "transaction count", ntx - base, 2 + exp_polls);
        check(tx_len[base % 64] == 8 && tx_data[base % 64][7:0] == 8'h06, "R3",
              "write-enable frame", {tx_len[base % 64], tx_data[base % 64][7:0]}, {32'd8, 8'h06});
        check(tx_len[(base + 1) % 64] == 32, "R4", "erase frame length",
              tx_len[(base + 1) % 64], 32);
        check(tx_data[(base + 1) % 64][31:24] == eop, "R4", "erase opcode",
              tx_data[(base + 1) % 64][31:24], eop);
        check(tx_data[(base + 1) % 64][23:0] == eaddr, "R5", "erase address",
              tx_data[(base + 1) % 64][23:0], eaddr);
        for (int k = 0; k < exp_polls; k++) begin
            check(tx_len[(base + 2 + k) % 64] == 16 &&
                  tx_data[(base + 2 + k) % 64][15:0] == 16'h0500, "R6", "status frame",
                  tx_data[(base + 2 + k) % 64][15:0], 16'h0500);
        end
        if (poke)
            check(ntx - base == 2 + exp_polls, "R11", "no extra frames from poke",
                  ntx - base, 2 + exp_polls);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        // R4 R5 R6: 4 KB sector, two busy reads then ready
        t_erase(2'd0, 24'h123ABC, 2, 8'h20, 24'h123000, 1'b0, 3, 1'b0);
        // R4 R5: 32 KB block, ready on first read
        t_erase(2'd1, 24'hFEDCBA, 0, 8'h52, 24'hFE8000, 1'b0, 1, 1'b0);
        // R4 R5: 64 KB block, one busy read
        t_erase(2'd2, 24'h5A7FFF, 1, 8'hD8, 24'h5A0000, 1'b0, 2, 1'b0);
        // R4 R11: selector 3 maps to 64 KB, request poked while busy
        t_erase(2'd3, 24'h00FFFF, 0, 8'hD8, 24'h000000, 1'b0, 1, 1'b1);
        // R8: flash never goes idle
        t_erase(2'd0, 24'h000FFF, 100, 8'h20, 24'h000000, 1'b1, POLL_LIMIT, 1'b0);
        check(min_gap >= MIN_GAP, "R10", "minimum cs high gap", min_gap, MIN_GAP);
        check(mode_viol == 0, "R9", "sck high while deselected", mode_viol, 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule